// File: doc/BRIEF.md
# Virtual Address Translation Sequencer with Directory Cache

This block turns one virtual address at a time into a physical address, a page fault or an unrecoverable error. It keeps a translation-table root register and a current address-space tag. A request is first looked up in a translation buffer whose entries are tagged with the address-space tag. When that misses, a small cache of first-level results is tried. This cache is keyed by tag and by the top twelve address bits. A hit there costs one memory fetch, the second-level one. A miss there costs the complete two-level walk over a simple read port. Each walk refills whichever caches it learned something for.

The translation buffer holds both 1 MB section mappings and 4 KB page mappings. An entry can go stale while a first-level descriptor is rewritten, and the directory cache can lose that descriptor to replacement. Two buffer entries may then cover the same address. Such an inconsistent hit raises an unrecoverable error, and the block accepts no further requests until reset. Every response carries a write-permission flag. A store whose translation raised any exception must not go to memory. A load still receives its response.

Top module: `mmu_xlat_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_rd_req are 0, both caches are empty, and the root and tag registers are 0.
- R2: A request that hits one valid non-fault buffer entry returns its physical address with no memory read.
- R3: When both caches miss, the block reads the first-level descriptor at root + VA[31:20]*4. If bits[1:0] are 01, it reads the second-level descriptor at {desc[31:10], VA[19:12], 00}. If bit 1 of that descriptor is set, the result is {desc[31:12], VA[11:0]}. That page mapping is installed in the buffer, so a later request in the same page needs no read.
- R4: A buffer miss that hits a directory-cache table entry performs exactly one read, the second-level fetch, returns the translated address and installs the page mapping.
- R5: A first-level descriptor with bits[1:0] = 10 is a section. The result is {desc[31:20], VA[19:0]} after one read. A buffer entry covering the whole 1 MB is installed, and the directory cache is not touched.
- R6: A first-level descriptor with bits[1:0] of 00 or 11 gives a page fault. A fault marker is cached for that tag and 1 MB region, so a repeat in that region faults with no read.
- R7: A second-level descriptor with bit 1 clear gives a page fault. A fault buffer entry is installed, so a repeat in that page faults with no read.
- R8: Entries match only under the address-space tag they were filled with. After a tag change the same address walks again, and entries filled under the earlier tag still hit once that tag is restored.
- R9: The first-level address is formed from the current value of the root register.
- R10: rsp_store_ok is 1 only for a write request whose response is neither fault nor fatal. A read that faults still gets rsp_valid.
- R11: Two buffer entries matching one request raise rsp_fatal. After that response, req_ready stays 0 and nothing is accepted until reset.
- R12: Both caches replace round-robin. Once the directory cache is full, the oldest region is evicted, and a request to that region walks its first level again.
- R13: One translation is outstanding at a time. The response holds its values while rsp_ready is 0, and req_ready is 0 until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_root_we | input | 1 | Load the translation-table root register |
| cfg_root | input | 32 | New root value |
| cfg_asid_we | input | 1 | Load the current address-space tag |
| cfg_asid | input | 8 | New tag value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and not halted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is for a store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | 32 | Physical address (0 on exception) |
| rsp_fault | output | 1 | Page fault |
| rsp_fatal | output | 1 | Unrecoverable inconsistent-hit error |
| rsp_store_ok | output | 1 | Store may be performed |
| mem_rd_req | output | 1 | Descriptor read request, held until data returns |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Descriptor word |

## Verification
The bench builds the block with eight buffer entries and only two directory-cache entries. Two entries are enough to evict a cached region within a handful of requests. That brings re-walks after replacement within reach, and also the stale page entry plus fresh section entry overlap that is the only path to an inconsistent hit. Eight buffer entries keep the vector table free of buffer evictions, so each expected read count follows from the directory cache alone.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;

    localparam int ASID_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH_L1,
        ST_FETCH_L2,
        ST_RESP
    } xlat_state_e;

    typedef enum logic [1:0] {
        L1_FAULT,
        L1_TABLE,
        L1_SECTION
    } l1_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic              section;
        logic [19:0]       vtag;
        logic [19:0]       ptag;
        logic              fault;
    } tlb_entry_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [11:0]       region;
        logic [21:0]       tbase;
        logic              fault;
    } dir_entry_t;

    function automatic l1_kind_e l1_decode(input logic [31:0] d);
        case (d[1:0])
            2'b01:   return L1_TABLE;
            2'b10:   return L1_SECTION;
            default: return L1_FAULT;
        endcase
    endfunction

    function automatic logic tlb_match(input tlb_entry_t e, input logic [ASID_W-1:0] asid,
                                       input logic [31:0] va);
        logic tag_ok;
        tag_ok = e.section ? (e.vtag[19:8] == va[31:20]) : (e.vtag == va[31:12]);
        return e.valid && (e.asid == asid) && tag_ok;
    endfunction

    function automatic logic dir_match(input dir_entry_t e, input logic [ASID_W-1:0] asid,
                                       input logic [31:0] va);
        return e.valid && (e.asid == asid) && (e.region == va[31:20]);
    endfunction

    function automatic logic [31:0] tlb_pa(input tlb_entry_t e, input logic [31:0] va);
        return e.section ? {e.ptag[19:8], va[19:0]} : {e.ptag, va[11:0]};
    endfunction

    function automatic logic [31:0] l1_addr(input logic [31:0] root, input logic [31:0] va);
        return root + {18'b0, va[31:20], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [21:0] tbase, input logic [31:0] va);
        return {tbase, va[19:12], 2'b00};
    endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import mmu_xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [31:0]       lk_va,
    output logic              lk_hit,
    output logic              lk_multi,
    output tlb_entry_t        lk_entry,
    input  logic              fill_en,
    input  tlb_entry_t        fill_entry
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0]   match;
    logic [IDX_W-1:0]     ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tlb_match(ent_q[g], lk_asid, lk_va);
    end

    always_comb begin
        lk_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_entry = tlb_entry_t'(lk_entry | ent_q[i]);
        end
        lk_hit   = |match;
        lk_multi = $countones(match) > 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else if (fill_en) begin
            ent_q[ptr_q] <= fill_entry;
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Every install carries a live entry (R3, R12)
    assert_fill_live_R12: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> fill_entry.valid);

    // An installed entry is found by a lookup for the address it was filled with (R3)
    assert_fill_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_entry.asid == lk_asid && lk_va[31:12] == fill_entry.vtag)
            |=> ($stable(lk_asid) && $stable(lk_va)) -> lk_hit);
endmodule

// File: rtl/xlat_dir_cache.sv
module xlat_dir_cache
    import mmu_xlat_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [31:0]       lk_va,
    output logic              lk_hit,
    output logic              lk_multi,
    output dir_entry_t        lk_entry,
    input  logic              fill_en,
    input  dir_entry_t        fill_entry
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    dir_entry_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0]   match;
    logic [IDX_W-1:0]     ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = dir_match(ent_q[g], lk_asid, lk_va);
    end

    always_comb begin
        lk_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_entry = dir_entry_t'(lk_entry | ent_q[i]);
        end
        lk_hit   = |match;
        lk_multi = $countones(match) > 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else if (fill_en) begin
            ent_q[ptr_q] <= fill_entry;
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Region entries are only filled after a miss, so at most one matches (R11)
    assert_dir_single_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // A fault marker never names a table base (R6)
    assert_marker_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_entry.fault) |-> fill_entry.tbase == '0);
endmodule

// File: rtl/mmu_xlat_top.sv
module mmu_xlat_top
    import mmu_xlat_pkg::*;
#(
    parameter int TLB_ENTRIES = 8,
    parameter int DIR_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_root_we,
    input  logic [31:0]       cfg_root,
    input  logic              cfg_asid_we,
    input  logic [ASID_W-1:0] cfg_asid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_pa,
    output logic              rsp_fault,
    output logic              rsp_fatal,
    output logic              rsp_store_ok,
    output logic              mem_rd_req,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data
);
    xlat_state_e       st_q;
    logic [31:0]       root_q;
    logic [ASID_W-1:0] asid_q;
    logic [31:0]       va_q;
    logic              wr_q;
    logic              halted_q;
    logic [31:0]       walk_addr_q;
    logic [31:0]       pa_q;
    logic              fault_q;
    logic              fatal_q;

    logic       tlb_hit, tlb_multi, tlb_fill_en;
    tlb_entry_t tlb_ent, tlb_fill;
    logic       dir_hit, dir_multi, dir_fill_en;
    dir_entry_t dir_ent, dir_fill;
    l1_kind_e   l1_kind;

    xlat_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst(rst), .lk_asid(asid_q), .lk_va(va_q),
        .lk_hit(tlb_hit), .lk_multi(tlb_multi), .lk_entry(tlb_ent),
        .fill_en(tlb_fill_en), .fill_entry(tlb_fill)
    );

    xlat_dir_cache #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk(clk), .rst(rst), .lk_asid(asid_q), .lk_va(va_q),
        .lk_hit(dir_hit), .lk_multi(dir_multi), .lk_entry(dir_ent),
        .fill_en(dir_fill_en), .fill_entry(dir_fill)
    );

    assign l1_kind = l1_decode(mem_rd_data);

    // Cache installs happen on the cycle a descriptor word arrives
    always_comb begin
        tlb_fill_en = 1'b0;
        tlb_fill    = '0;
        dir_fill_en = 1'b0;
        dir_fill    = '0;
        if (st_q == ST_FETCH_L1 && mem_rd_valid) begin
            case (l1_kind)
                L1_SECTION: begin
                    tlb_fill_en      = 1'b1;
                    tlb_fill.valid   = 1'b1;
                    tlb_fill.asid    = asid_q;
                    tlb_fill.section = 1'b1;
                    tlb_fill.vtag    = va_q[31:12];
                    tlb_fill.ptag    = {mem_rd_data[31:20], 8'b0};
                end
                L1_TABLE: begin
                    dir_fill_en     = 1'b1;
                    dir_fill.valid  = 1'b1;
                    dir_fill.asid   = asid_q;
                    dir_fill.region = va_q[31:20];
                    dir_fill.tbase  = mem_rd_data[31:10];
                end
                default: begin
                    dir_fill_en     = 1'b1;
                    dir_fill.valid  = 1'b1;
                    dir_fill.asid   = asid_q;
                    dir_fill.region = va_q[31:20];
                    dir_fill.fault  = 1'b1;
                end
            endcase
        end else if (st_q == ST_FETCH_L2 && mem_rd_valid) begin
            tlb_fill_en    = 1'b1;
            tlb_fill.valid = 1'b1;
            tlb_fill.asid  = asid_q;
            tlb_fill.vtag  = va_q[31:12];
            tlb_fill.ptag  = mem_rd_data[1] ? mem_rd_data[31:12] : 20'b0;
            tlb_fill.fault = !mem_rd_data[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            root_q      <= '0;
            asid_q      <= '0;
            va_q        <= '0;
            wr_q        <= 1'b0;
            halted_q    <= 1'b0;
            walk_addr_q <= '0;
            pa_q        <= '0;
            fault_q     <= 1'b0;
            fatal_q     <= 1'b0;
        end else begin
            if (cfg_root_we) root_q <= cfg_root;
            if (cfg_asid_we) asid_q <= cfg_asid;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid && !halted_q) begin
                        va_q    <= req_va;
                        wr_q    <= req_write;
                        pa_q    <= '0;
                        fault_q <= 1'b0;
                        fatal_q <= 1'b0;
                        st_q    <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (tlb_multi) begin
                        fatal_q  <= 1'b1;
                        halted_q <= 1'b1;
                        st_q     <= ST_RESP;
                    end else if (tlb_hit) begin
                        fault_q <= tlb_ent.fault;
                        pa_q    <= tlb_ent.fault ? 32'b0 : tlb_pa(tlb_ent, va_q);
                        st_q    <= ST_RESP;
                    end else if (dir_multi) begin
                        fatal_q  <= 1'b1;
                        halted_q <= 1'b1;
                        st_q     <= ST_RESP;
                    end else if (dir_hit) begin
                        if (dir_ent.fault) begin
                            fault_q <= 1'b1;
                            st_q    <= ST_RESP;
                        end else begin
                            walk_addr_q <= l2_addr(dir_ent.tbase, va_q);
                            st_q        <= ST_FETCH_L2;
                        end
                    end else begin
                        walk_addr_q <= l1_addr(root_q, va_q);
                        st_q        <= ST_FETCH_L1;
                    end
                end
                ST_FETCH_L1: begin
                    if (mem_rd_valid) begin
                        case (l1_kind)
                            L1_TABLE: begin
                                walk_addr_q <= l2_addr(mem_rd_data[31:10], va_q);
                                st_q        <= ST_FETCH_L2;
                            end
                            L1_SECTION: begin
                                pa_q <= {mem_rd_data[31:20], va_q[19:0]};
                                st_q <= ST_RESP;
                            end
                            default: begin
                                fault_q <= 1'b1;
                                st_q    <= ST_RESP;
                            end
                        endcase
                    end
                end
                ST_FETCH_L2: begin
                    if (mem_rd_valid) begin
                        fault_q <= !mem_rd_data[1];
                        pa_q    <= mem_rd_data[1] ? {mem_rd_data[31:12], va_q[11:0]} : 32'b0;
                        st_q    <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st_q == ST_IDLE) && !halted_q;
    assign rsp_valid    = (st_q == ST_RESP);
    assign rsp_pa       = pa_q;
    assign rsp_fault    = fault_q;
    assign rsp_fatal    = fatal_q;
    assign rsp_store_ok = rsp_valid && wr_q && !fault_q && !fatal_q;
    assign mem_rd_req   = (st_q == ST_FETCH_L1) || (st_q == ST_FETCH_L2);
    assign mem_rd_addr  = walk_addr_q;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && !mem_rd_req && req_ready));

    assert_read_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

    assert_single_outstanding_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_halt_after_fatal_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fatal) |=> !req_ready);

    assert_store_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault || rsp_fatal)) |-> !rsp_store_ok);
endmodule

// File: tb/tb_mmu_xlat_top.sv
module tb_mmu_xlat_top;
    import mmu_xlat_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_root_we = 1'b0;
    logic [31:0]       cfg_root = '0;
    logic              cfg_asid_we = 1'b0;
    logic [ASID_W-1:0] cfg_asid = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_va = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [31:0]       rsp_pa;
    logic              rsp_fault, rsp_fatal, rsp_store_ok;
    logic              mem_rd_req;
    logic [31:0]       mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [31:0]       mem_rd_data = '0;

    always #10 clk = ~clk;

    mmu_xlat_top #(.TLB_ENTRIES(8), .DIR_ENTRIES(2)) dut (
        .clk(clk), .rst(rst),
        .cfg_root_we(cfg_root_we), .cfg_root(cfg_root),
        .cfg_asid_we(cfg_asid_we), .cfg_asid(cfg_asid),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_fatal(rsp_fatal), .rsp_store_ok(rsp_store_ok),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // Descriptor memory: word index addr[11:2], one-cycle response
    logic [31:0] mem [0:1023];
    int          rd_count = 0;
    logic [31:0] rd_log [0:15];

    always @(posedge clk) begin
        if (mem_rd_req && !mem_rd_valid) begin
            mem_rd_valid        <= 1'b1;
            mem_rd_data         <= mem[mem_rd_addr[11:2]];
            rd_log[rd_count % 16] <= mem_rd_addr;
            rd_count            <= rd_count + 1;
        end else begin
            mem_rd_valid <= 1'b0;
        end
    end

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails <= fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer than 150000", cycles);
            #1 summary_and_end();
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] g_pa;
    logic        g_fault, g_fatal, g_store;
    int          g_reads;
    int          g_mark;

    task automatic xlat(input logic w, input logic [31:0] va, input logic hold);
        int guard;
        g_mark    = rd_count;
        rsp_ready = !hold;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = w;
        guard = 0;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 1000) begin @(negedge clk); guard++; end
        if (guard >= 1000) check(1'b0, "handshake timeout", 32'd0, 32'd1);
        g_pa = rsp_pa; g_fault = rsp_fault; g_fatal = rsp_fatal; g_store = rsp_store_ok;
        g_reads = rd_count - g_mark;
        if (hold) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(rsp_valid && rsp_pa == g_pa && !req_ready, "R13 response held",
                      {30'b0, rsp_valid, req_ready}, 32'h2);
            end
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        check(!rsp_valid, "R13 response released", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_asid(input logic [ASID_W-1:0] a);
        @(negedge clk); cfg_asid = a; cfg_asid_we = 1'b1;
        @(negedge clk); cfg_asid_we = 1'b0;
    endtask

    task automatic set_root(input logic [31:0] r);
        @(negedge clk); cfg_root = r; cfg_root_we = 1'b1;
        @(negedge clk); cfg_root_we = 1'b0;
    endtask

    // {tag[3:0], write, va[31:0], fault, pa[31:0], reads[3:0]}
    localparam int NV = 13;
    localparam logic [73:0] VEC [NV] = '{
        {4'd3,  1'b0, 32'h0010_3ABC, 1'b0, 32'h1234_5ABC, 4'd2}, // R3 full walk
        {4'd2,  1'b0, 32'h0010_3000, 1'b0, 32'h1234_5000, 4'd0}, // R2 hit
        {4'd4,  1'b1, 32'h0010_4010, 1'b0, 32'h2222_2010, 4'd1}, // R4 partial walk, R10 store
        {4'd5,  1'b0, 32'h0040_1234, 1'b0, 32'hABC0_1234, 4'd1}, // R5 section
        {4'd5,  1'b0, 32'h0047_7777, 1'b0, 32'hABC7_7777, 4'd0}, // R5 same MB hit
        {4'd6,  1'b1, 32'h0030_0000, 1'b1, 32'h0000_0000, 4'd1}, // R6 L1 fault, R10 store blocked
        {4'd6,  1'b0, 32'h0030_5000, 1'b1, 32'h0000_0000, 4'd0}, // R6 cached marker
        {4'd7,  1'b0, 32'h0010_7000, 1'b1, 32'h0000_0000, 4'd1}, // R7 L2 fault
        {4'd7,  1'b0, 32'h0010_7444, 1'b1, 32'h0000_0000, 4'd0}, // R7 fault entry hit
        {4'd12, 1'b0, 32'h0020_1008, 1'b0, 32'h3333_3008, 4'd2}, // R12 evicts region 1
        {4'd12, 1'b0, 32'h0010_5000, 1'b1, 32'h0000_0000, 4'd2}, // R12 region 1 re-walked
        {4'd12, 1'b0, 32'h0030_0000, 1'b1, 32'h0000_0000, 4'd1}, // R12 region 3 re-walked
        {4'd3,  1'b0, 32'h0050_0ABC, 1'b0, 32'h4444_4ABC, 4'd2}  // R3 third table
    };

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[32'h004 >> 2] = 32'h0000_0401;  // region 1 -> table 0x400
        mem[32'h008 >> 2] = 32'h0000_0801;  // region 2 -> table 0x800
        mem[32'h00C >> 2] = 32'h0000_0000;  // region 3 fault
        mem[32'h010 >> 2] = 32'hABC0_0002;  // region 4 section
        mem[32'h014 >> 2] = 32'h0000_0C01;  // region 5 -> table 0xC00
        mem[32'h40C >> 2] = 32'h1234_5002;
        mem[32'h410 >> 2] = 32'h2222_2002;
        mem[32'h804 >> 2] = 32'h3333_3002;
        mem[32'hC00 >> 2] = 32'h4444_4002;
        mem[32'h204 >> 2] = 32'h0000_0401;  // region 1 under root 0x200

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_valid && !mem_rd_req, "R1 reset outputs",
              {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'h4);
        set_asid(8'h05);

        for (int v = 0; v < NV; v++) begin
            logic [73:0] e;
            e = VEC[v];
            xlat(e[69], e[68:37], 1'b0);
            if (g_fault != e[36] || g_fatal) begin
                checks++; fails++;
                $display("FAIL vec %0d (R%0d) fault: actual %0d expected %0d", v, e[73:70], g_fault, e[36]);
            end else checks++;
            if (!e[36]) check(g_pa == e[35:4], $sformatf("vec %0d (R%0d) address", v, e[73:70]), g_pa, e[35:4]);
            check(g_reads == int'(e[3:0]), $sformatf("vec %0d (R%0d) read count", v, e[73:70]),
                  g_reads, {28'b0, e[3:0]});
            check(g_store == (e[69] && !e[36]), $sformatf("vec %0d (R10) store permission", v),
                  {31'b0, g_store}, {31'b0, e[69] && !e[36]});
        end

        // R13: response held while not taken
        xlat(1'b0, 32'h0010_3000, 1'b1);
        check(g_pa == 32'h1234_5000 && g_reads == 0, "R13 held hit address", g_pa, 32'h1234_5000);

        // R8: tag isolation
        set_asid(8'h06);
        xlat(1'b0, 32'h0010_3ABC, 1'b0);
        check(g_reads == 2, "R8 new tag walks", g_reads, 2);
        set_asid(8'h05);
        xlat(1'b0, 32'h0010_3ABC, 1'b0);
        check(g_reads == 0 && g_pa == 32'h1234_5ABC, "R8 old tag entry kept", g_reads, 0);

        // R9: root register used for first-level address
        set_root(32'h0000_0200);
        set_asid(8'h07);
        xlat(1'b0, 32'h0010_0000, 1'b0);
        check(rd_log[g_mark % 16] == 32'h0000_0204, "R9 first-level address", rd_log[g_mark % 16], 32'h204);
        check(g_fault && g_reads == 2, "R9 walk under new root", g_reads, 2);

        // R11: stale page entry plus new section entry overlap
        do_reset();
        check(req_ready && !rsp_valid, "R1 second reset", {31'b0, req_ready}, 32'd1);
        set_asid(8'h05);
        xlat(1'b0, 32'h0010_3ABC, 1'b0);
        xlat(1'b0, 32'h0020_1008, 1'b0);
        xlat(1'b0, 32'h0050_0ABC, 1'b0);
        check(g_reads == 2, "R12 region 5 evicts region 1", g_reads, 2);
        @(negedge clk);
        mem[32'h004 >> 2] = 32'h0990_0002;
        xlat(1'b0, 32'h0015_0000, 1'b0);
        check(g_pa == 32'h0995_0000 && g_reads == 1, "R5 section after rewrite", g_pa, 32'h0995_0000);
        xlat(1'b1, 32'h0010_3ABC, 1'b0);
        check(g_fatal && g_reads == 0, "R11 inconsistent hit fatal", {31'b0, g_fatal}, 32'd1);
        check(!g_store, "R10 store blocked on fatal", {31'b0, g_store}, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h0010_3000;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!req_ready && !rsp_valid && !mem_rd_req, "R11 halted",
                  {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'd0);
        end
        req_valid = 1'b0;
        do_reset();
        check(req_ready && !rsp_valid, "R1 reset clears halt", {31'b0, req_ready}, 32'd1);

        summary_and_end();
    end
endmodule